// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Read Latency

This block is a true dual-port synchronous memory. Two ports, left and right, can each read or write any word in the same cycle as the other. Each port registers its address, write data and control on the rising clock edge. A port is active only when its active-low enable is low and its active-high enable is high. The port's read/write select then decides between a write and a read.

Each port has a static strap that sets its read latency. In flow-through mode, read data is driven in the cycle right after the capture edge. In pipelined mode, an extra output register delays the data by one more cycle. Each port's output is modelled as a data bus plus a drive-enable. The drive-enable is gated by an asynchronous active-low output enable.

Both ports run from one shared clock, so "the same cycle" has a precise meaning for the collision policy:

- When both ports write one word in the same cycle, the left port's data is kept.
- A read that meets a write to the same word on the other port returns the word's old contents.

The depth is `2**ADDR_W` words, and `ADDR_W = 14` gives the full 16K configuration. Setting `HALF_DEPTH` ignores the top address bit.

Top module: `dpSyncRam`

## Requirements
- R1: Address, write data, enables and read/write select are captured on the rising clock edge. A captured write is stored and returned by a later read of the same address.
- R2: A port is selected only when its `Ce0N` is 0 and its `Ce1` is 1. With any other combination, a write stores nothing and a read leaves the drive-enable at 0.
- R3: When selected, `Rnw = 0` writes and `Rnw = 1` reads. A write never asserts the port's drive-enable.
- R4: With `Pipe = 0` (flow-through), a read captured at edge E drives `Doe = 1` and the stored data from E until the next edge only.
- R5: With `Pipe = 1` (pipelined), the read data and `Doe = 1` appear one clock edge later than in flow-through mode, and not before.
- R6: `OeN = 1` forces `Doe` to 0 at once, without waiting for a clock edge. Returning `OeN` to 0 within the same cycle restores the drive.
- R7: Both ports can read the same address in the same cycle, and each returns the stored word.
- R8: When both ports write the same address in the same cycle, the left port's data is stored.
- R9: A read on one port captured in the same cycle as a write to that address on the other port returns the old data. A later read returns the new data.
- R10: With `HALF_DEPTH = 1`, the top address bit is ignored, so two addresses that differ only in that bit reach the same word.
- R11: While reset is asserted and after it is released, both drive-enables stay at 0 until a selected read has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| lCe0N | input | 1 | Left port enable, active low |
| lCe1 | input | 1 | Left port enable, active high |
| lRnw | input | 1 | Left port select: 1 read, 0 write |
| lOeN | input | 1 | Left port asynchronous output enable, active low |
| lPipe | input | 1 | Left port latency strap: 0 flow-through, 1 pipelined |
| lAddr | input | ADDR_W | Left port address |
| lDin | input | DATA_W | Left port write data |
| lDout | output | DATA_W | Left port read data, valid when lDoe is 1 |
| lDoe | output | 1 | Left port drive-enable (0 means high impedance) |
| rCe0N | input | 1 | Right port enable, active low |
| rCe1 | input | 1 | Right port enable, active high |
| rRnw | input | 1 | Right port select: 1 read, 0 write |
| rOeN | input | 1 | Right port asynchronous output enable, active low |
| rPipe | input | 1 | Right port latency strap: 0 flow-through, 1 pipelined |
| rAddr | input | ADDR_W | Right port address |
| rDin | input | DATA_W | Right port write data |
| rDout | output | DATA_W | Right port read data, valid when rDoe is 1 |
| rDoe | output | 1 | Right port drive-enable (0 means high impedance) |

## Verification
The bench drives all inputs on the falling edge, so each request is captured at the next rising edge E.

- **Flow-through results:** the left port is strapped flow-through, so its result is due on the falling edge that follows E. The bench samples it there, and on the next falling edge it confirms that the drive has been withdrawn.
- **Pipelined results:** the right port is strapped pipelined. The bench first confirms that its drive-enable is still 0 half a cycle after E, then samples the data one edge later.
- **Writes:** a write captured at E is committed at the following edge. Reads that must see it are therefore captured no earlier than that edge. Collision reads are captured together with the write, so they observe the old word.
- **Output enable:** it is toggled mid-cycle, away from any edge, to show that it acts without a clock.

// File: rtl/dpRamPkg.sv
package dpRamPkg;

  // Strobes handed from a port's control to the shared datapath.
  typedef struct packed {
    logic wrEn;    // registered request is a selected write
    logic rdLive;  // registered request is a selected read (flow-through stage)
    logic rdHeld;  // selected read one cycle older (pipelined stage)
  } portStb_t;

  localparam int NPORT = 2;  // index 0 is the left port, 1 the right

endpackage

// File: rtl/dpPortCtrl.sv
module dpPortCtrl
  import dpRamPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ce0N,
  input  logic     ce1,
  input  logic     rnw,
  input  logic     oeN,
  input  logic     pipeMode,
  output portStb_t stb,
  output logic     dataOe
);

  logic selQ;
  logic rnwQ;
  logic rdHeldQ;
  logic selIn;

  assign selIn = !ce0N && ce1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= 1'b0;
      rnwQ    <= 1'b1;
      rdHeldQ <= 1'b0;
    end else begin
      selQ    <= selIn;
      rnwQ    <= rnw;
      rdHeldQ <= selQ && rnwQ;
    end
  end

  assign stb.wrEn   = selQ && !rnwQ;
  assign stb.rdLive = selQ && rnwQ;
  assign stb.rdHeld = rdHeldQ;

  // Output enable acts without a clock; the strap picks the stage.
  assign dataOe = !oeN && (pipeMode ? rdHeldQ : stb.rdLive);

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && !selIn) |=> !dataOe);  // R2
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && selIn && !rnw) |=> !dataOe);  // R3
  AST_PIPE_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && !(selIn && rnw)) |=> ##1 !dataOe);  // R5
  AST_PIPE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && !rdHeldQ && !(selQ && rnwQ)) |=> !dataOe);  // R5

endmodule

// File: rtl/dpRamCore.sv
module dpRamCore
  import dpRamPkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 9,
  parameter bit HALF_DEPTH = 1'b0
) (
  input  logic                           clk,
  input  logic [NPORT-1:0][ADDR_W-1:0]   addrIn,
  input  logic [NPORT-1:0][DATA_W-1:0]   dinIn,
  input  portStb_t [NPORT-1:0]           stbIn,
  input  logic [NPORT-1:0]               pipeIn,
  output logic [NPORT-1:0][DATA_W-1:0]   doutAll
);

  localparam int EFF_W = HALF_DEPTH ? ADDR_W - 1 : ADDR_W;
  localparam int WORDS = 1 << EFF_W;

  logic [DATA_W-1:0] mem [WORDS];

  logic [NPORT-1:0][EFF_W-1:0]  addrAll;
  logic [NPORT-1:0][DATA_W-1:0] dinAll;
  logic [NPORT-1:0]             wrAll;

  for (genvar p = 0; p < NPORT; p++) begin : gPort
    logic [EFF_W-1:0]  addrQ;
    logic [DATA_W-1:0] dinQ;
    logic [DATA_W-1:0] rdData;
    logic [DATA_W-1:0] pipeQ;

    always_ff @(posedge clk) begin
      addrQ <= addrIn[p][EFF_W-1:0];
      dinQ  <= dinIn[p];
      pipeQ <= rdData;   // sampled before this edge's write lands
    end

    assign rdData     = mem[addrQ];
    assign addrAll[p] = addrQ;
    assign dinAll[p]  = dinQ;
    assign wrAll[p]   = stbIn[p].wrEn;
    assign doutAll[p] = pipeIn[p] ? pipeQ : rdData;
  end

  // Highest index first so the left port (index 0) lands last and wins.
  always_ff @(posedge clk) begin
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (wrAll[p]) mem[addrAll[p]] <= dinAll[p];
    end
  end

  AST_LEFT_WINS: assert property (@(posedge clk)
    (wrAll[0] && wrAll[1] && addrAll[0] == addrAll[1])
      |=> mem[$past(addrAll[0])] == $past(dinAll[0]));  // R8

endmodule

// File: rtl/dpSyncRam.sv
module dpSyncRam
  import dpRamPkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 9,
  parameter bit HALF_DEPTH = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCe0N,
  input  logic              lCe1,
  input  logic              lRnw,
  input  logic              lOeN,
  input  logic              lPipe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lDin,
  output logic [DATA_W-1:0] lDout,
  output logic              lDoe,
  input  logic              rCe0N,
  input  logic              rCe1,
  input  logic              rRnw,
  input  logic              rOeN,
  input  logic              rPipe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rDin,
  output logic [DATA_W-1:0] rDout,
  output logic              rDoe
);

  logic [NPORT-1:0]             ce0NAll, ce1All, rnwAll, oeNAll, pipeAll, doeAll;
  logic [NPORT-1:0][ADDR_W-1:0] addrAll;
  logic [NPORT-1:0][DATA_W-1:0] dinAll, doutAll;
  portStb_t [NPORT-1:0]         stbAll;

  assign ce0NAll = {rCe0N, lCe0N};
  assign ce1All  = {rCe1, lCe1};
  assign rnwAll  = {rRnw, lRnw};
  assign oeNAll  = {rOeN, lOeN};
  assign pipeAll = {rPipe, lPipe};
  assign addrAll = {rAddr, lAddr};
  assign dinAll  = {rDin, lDin};

  for (genvar p = 0; p < NPORT; p++) begin : gCtrl
    dpPortCtrl uCtrl (
      .clk      (clk),
      .rstN     (rstN),
      .ce0N     (ce0NAll[p]),
      .ce1      (ce1All[p]),
      .rnw      (rnwAll[p]),
      .oeN      (oeNAll[p]),
      .pipeMode (pipeAll[p]),
      .stb      (stbAll[p]),
      .dataOe   (doeAll[p])
    );
  end

  dpRamCore #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .HALF_DEPTH (HALF_DEPTH)
  ) uCore (
    .clk     (clk),
    .addrIn  (addrAll),
    .dinIn   (dinAll),
    .stbIn   (stbAll),
    .pipeIn  (pipeAll),
    .doutAll (doutAll)
  );

  assign lDout = doutAll[0];
  assign rDout = doutAll[1];
  assign lDoe  = doeAll[0];
  assign rDoe  = doeAll[1];

endmodule

// File: tb/sim_dpSyncRam.sv
module sim_dpSyncRam;

  localparam int AW = 11;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCe0N = 1'b1, lCe1 = 1'b0, lRnw = 1'b1, lOeN = 1'b0;
  logic rCe0N = 1'b1, rCe1 = 1'b0, rRnw = 1'b1, rOeN = 1'b0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lDin = '0, rDin = '0;
  logic [DW-1:0] lDout, rDout, hDout, hRDout;
  logic lDoe, rDoe, hDoe, hRDoe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dpSyncRam #(.ADDR_W(AW), .DATA_W(DW), .HALF_DEPTH(1'b0)) u0 (
    .clk(clk), .rstN(rstN),
    .lCe0N(lCe0N), .lCe1(lCe1), .lRnw(lRnw), .lOeN(lOeN), .lPipe(1'b0),
    .lAddr(lAddr), .lDin(lDin), .lDout(lDout), .lDoe(lDoe),
    .rCe0N(rCe0N), .rCe1(rCe1), .rRnw(rRnw), .rOeN(rOeN), .rPipe(1'b1),
    .rAddr(rAddr), .rDin(rDin), .rDout(rDout), .rDoe(rDoe)
  );

  // Half-depth copy sharing the left-port stimulus; right port idle.
  dpSyncRam #(.ADDR_W(AW), .DATA_W(DW), .HALF_DEPTH(1'b1)) u1 (
    .clk(clk), .rstN(rstN),
    .lCe0N(lCe0N), .lCe1(lCe1), .lRnw(lRnw), .lOeN(lOeN), .lPipe(1'b0),
    .lAddr(lAddr), .lDin(lDin), .lDout(hDout), .lDoe(hDoe),
    .rCe0N(1'b1), .rCe1(1'b0), .rRnw(1'b1), .rOeN(1'b0), .rPipe(1'b0),
    .rAddr('0), .rDin('0), .rDout(hRDout), .rDoe(hRDoe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic setL(input logic c0n, input logic c1, input logic rnw,
                      input int addr, input int din);
    lCe0N = c0n; lCe1 = c1; lRnw = rnw; lAddr = AW'(addr); lDin = DW'(din);
  endtask

  task automatic setR(input logic c0n, input logic c1, input logic rnw,
                      input int addr, input int din);
    rCe0N = c0n; rCe1 = c1; rRnw = rnw; rAddr = AW'(addr); rDin = DW'(din);
  endtask

  task automatic idle();
    lCe0N = 1'b1; lCe1 = 1'b0; rCe0N = 1'b1; rCe1 = 1'b0;
  endtask

  task automatic tReset();
    chk("R11 left doe in reset", int'(lDoe), 0);
    chk("R11 right doe in reset", int'(rDoe), 0);
    rstN = 1'b1;
    step();
    chk("R11 left doe after reset", int'(lDoe), 0);
    chk("R11 right doe after reset", int'(rDoe), 0);
  endtask

  task automatic tWriteRead();
    setL(1'b0, 1'b1, 1'b0, 10, 'h1A5);
    step();
    chk("R3 no drive during write", int'(lDoe), 0);
    setL(1'b0, 1'b1, 1'b1, 10, 0);
    step();
    chk("R4 flow doe", int'(lDoe), 1);
    chk("R1 flow data", int'(lDout), 'h1A5);
    idle();
    step();
    chk("R4 flow drive lasts one cycle", int'(lDoe), 0);
  endtask

  task automatic tPipe();
    setR(1'b0, 1'b1, 1'b1, 10, 0);
    step();
    chk("R5 pipe not yet driven", int'(rDoe), 0);
    idle();
    step();
    chk("R5 pipe doe", int'(rDoe), 1);
    chk("R5 pipe data", int'(rDout), 'h1A5);
    step();
    chk("R5 pipe drive released", int'(rDoe), 0);
  endtask

  task automatic tSelect();
    setL(1'b0, 1'b1, 1'b0, 20, 'h055);
    step();
    setL(1'b1, 1'b1, 1'b0, 20, 'h1FF);
    step();
    setL(1'b0, 1'b0, 1'b0, 20, 'h1FE);
    step();
    setL(1'b1, 1'b0, 1'b0, 20, 'h1FD);
    step();
    setL(1'b1, 1'b1, 1'b1, 20, 0);
    step();
    chk("R2 deselect ce0N=1 ce1=1 no drive", int'(lDoe), 0);
    setL(1'b0, 1'b0, 1'b1, 20, 0);
    step();
    chk("R2 deselect ce0N=0 ce1=0 no drive", int'(lDoe), 0);
    setL(1'b0, 1'b1, 1'b1, 20, 0);
    step();
    chk("R2 deselected writes ignored", int'(lDout), 'h055);
    idle();
    step();
  endtask

  task automatic tOe();
    setL(1'b0, 1'b1, 1'b1, 10, 0);
    step();
    chk("R6 baseline drive", int'(lDoe), 1);
    lOeN = 1'b1;
    #1;
    chk("R6 oeN high drops drive", int'(lDoe), 0);
    lOeN = 1'b0;
    #1;
    chk("R6 oeN low restores drive", int'(lDoe), 1);
    chk("R6 data kept", int'(lDout), 'h1A5);
    idle();
    step();
  endtask

  task automatic tDualRead();
    setL(1'b0, 1'b1, 1'b1, 10, 0);
    setR(1'b0, 1'b1, 1'b1, 10, 0);
    step();
    chk("R7 left concurrent read", int'(lDout), 'h1A5);
    idle();
    step();
    chk("R7 right concurrent read doe", int'(rDoe), 1);
    chk("R7 right concurrent read", int'(rDout), 'h1A5);
  endtask

  task automatic tBothWrite();
    setL(1'b0, 1'b1, 1'b0, 30, 'h111);
    setR(1'b0, 1'b1, 1'b0, 30, 'h0EE);
    step();
    idle();
    step();
    setL(1'b0, 1'b1, 1'b1, 30, 0);
    step();
    chk("R8 left write wins", int'(lDout), 'h111);
    idle();
    step();
  endtask

  task automatic tReadDuringWrite();
    setL(1'b0, 1'b1, 1'b0, 40, 'h0AA);
    setR(1'b0, 1'b1, 1'b0, 41, 'h0CC);
    step();
    setL(1'b0, 1'b1, 1'b0, 40, 'h155);
    setR(1'b0, 1'b1, 1'b1, 40, 0);
    step();
    idle();
    step();
    chk("R9 pipe read sees old data", int'(rDout), 'h0AA);
    setR(1'b0, 1'b1, 1'b1, 40, 0);
    step();
    idle();
    step();
    chk("R9 later read sees new data", int'(rDout), 'h155);
    setR(1'b0, 1'b1, 1'b0, 41, 'h033);
    setL(1'b0, 1'b1, 1'b1, 41, 0);
    step();
    chk("R9 flow read sees old data", int'(lDout), 'h0CC);
    idle();
    step();
    setL(1'b0, 1'b1, 1'b1, 41, 0);
    step();
    chk("R9 flow later read new data", int'(lDout), 'h033);
    idle();
    step();
  endtask

  task automatic tHalf();
    setL(1'b0, 1'b1, 1'b0, (1 << (AW - 1)) | 7, 'h0D2);
    step();
    setL(1'b0, 1'b1, 1'b1, 7, 0);
    step();
    chk("R10 half-depth alias doe", int'(hDoe), 1);
    chk("R10 half-depth top bit ignored", int'(hDout), 'h0D2);
    chk("R10 full-depth keeps top bit", int'(lDout == 9'h0D2), 0);
    idle();
    step();
  endtask

  initial begin
    repeat (3) step();
    tReset();
    tWriteRead();
    tPipe();
    tSelect();
    tOe();
    tDualRead();
    tBothWrite();
    tReadDuringWrite();
    tHalf();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule